// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block is a master for a small three-wire serial EEPROM of the 16-bit-word kind. It drives chip select, a serial clock and the data line into the memory, and it samples the data line that comes back out. A host pulses `start_i` with a 4-bit word address. The block clocks out a 10-bit read command and then clocks in 16 data bits. It returns the word on `word_o` together with a one-cycle `done_o` pulse.

When `addr_mode_i` is high at start, the block ignores the given address and reads words 0, 1 and 2 back to back. It packs the three words into a 48-bit station address on `station_o`. Each phase of the serial clock, the chip-select setup time and the chip-select idle time are given as parameters in nanoseconds. The block turns them into system clock cycles, always rounding up.

Top module: `mw_eeprom_reader`

## Requirements
- R1: While reset is asserted and right after it, `ee_cs_o`, `ee_sk_o`, `ee_di_o`, `busy_o` and `done_o` are 0, and `word_o` and `station_o` are all zeros.
- R2: Every access shifts out a 10-bit command equal to 0x180 OR the 4-bit word address, most significant bit first, one bit per rising edge of `ee_sk_o`. `ee_di_o` only changes while `ee_sk_o` is low.
- R3: `ee_sk_o` is high only while `ee_cs_o` is high. From the rise of `ee_cs_o` to the first rise of `ee_sk_o` there are at least ceil(T_CSS_NS·f) cycles (50 at the defaults).
- R4: Each high phase of `ee_sk_o` lasts at least ceil(T_HIGH_NS·f) cycles, and at least SYNC_STAGES+1 cycles. Each low phase inside an access lasts at least the larger of ceil(T_LOW_NS·f) and ceil(T_SETUP_NS·f) cycles. At the defaults both are 100 cycles.
- R5: After the command, `ee_di_o` is 0 for 16 more clocks. The bit on `ee_do_i` in the high phase of each of those clocks is taken in, most significant bit first. The 16-bit result appears on `word_o`.
- R6: Each access has exactly 26 rising edges of `ee_sk_o` between the rise and the fall of `ee_cs_o`.
- R7: `ee_cs_o` falls after the last data bit. It then stays low for at least ceil(T_CSH_NS·f) cycles (50 at the defaults) before the next access. It is low whenever the block is idle.
- R8: `done_o` is a single-cycle pulse. In that cycle `busy_o` is already 0, and `word_o` and `station_o` hold their values until the next request completes.
- R9: A `start_i` pulse while `busy_o` is 1 is ignored. The running request finishes with its own address and mode, and no extra access is made.
- R10: In address mode the words at addresses 0, 1 and 2 are read in that order, and `station_o` = {word0, word1, word2`}`. Bits 47:40 are the upper byte of word 0. `word_o` ends holding word 2. Single reads leave `station_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, taken when idle |
| addr_mode_i | input | 1 | 1: read words 0..2 into the station address |
| word_addr_i | input | 4 | Word address for a single read |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| word_o | output | 16 | Last word read |
| station_o | output | 48 | Assembled 48-bit station address |
| ee_cs_o | output | 1 | EEPROM chip select, active high |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_di_o | output | 1 | Serial data into the EEPROM |
| ee_do_i | input | 1 | Serial data from the EEPROM |

## Verification
The bench models the EEPROM and records every command frame, the number of clock edges per access and any high data-in level during the data phase. A wrong command constant, a bit-order slip or a lost leading zero shows up as a wrong logged frame or a wrong word. Reading the data line at the wrong point relative to the two-stage synchronizer shifts the word by one bit.

Phase and chip-select windows are measured over the whole run. A design that rounds the cycle counts down, or skips the setup phase before the first clock, fails the minimum-time checks.

The bench sends a second start with a different address and mode in the middle of a read. A design that takes that start gives a wrong word, an extra frame or a changed station address. The address-mode run exposes swapped word order and swapped halves inside the 48-bit result.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int ADDR_W   = 4;
  localparam int WORD_W   = 16;
  localparam int FRAME_W  = 10;
  localparam int TOTAL_CLKS = FRAME_W + WORD_W;
  localparam int STATION_WORDS = 3;
  localparam int STATION_W = STATION_WORDS * WORD_W;
  localparam logic [FRAME_W-1:0] READ_CMD_BASE = 10'h180;

  typedef enum logic [2:0] {
    E_IDLE,
    E_CSS,
    E_LOW,
    E_HIGH,
    E_TAIL
  } eng_state_t;

  // Nanoseconds to clock cycles, rounded up.
  function automatic int ns_to_cyc(input int ns, input int khz);
    return (ns * khz + 999_999) / 1_000_000;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/mw_phase_timer.sv
module mw_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? load_val_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/mw_word_engine.sv
module mw_word_engine
  import mw_pkg::*;
#(
  parameter int CSS_C  = 50,
  parameter int LOW_C  = 100,
  parameter int HIGH_C = 100,
  parameter int CSH_C  = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              do_sync_i,
  output logic              cs_o,
  output logic              sk_o,
  output logic              di_o,
  output logic [WORD_W-1:0] word_o,
  output logic              done_o
);
  localparam int CW    = $clog2(imax(imax(CSS_C, LOW_C), imax(HIGH_C, CSH_C)) + 1);
  localparam int BIT_W = $clog2(TOTAL_CLKS);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(TOTAL_CLKS - 1);
  localparam logic [BIT_W-1:0] FIRST_RX  = BIT_W'(FRAME_W);

  eng_state_t          state_q, state_d;
  logic [FRAME_W-1:0]  tx_q, tx_d;
  logic [WORD_W-1:0]   rx_q, rx_d;
  logic [BIT_W-1:0]    bit_q, bit_d;
  logic                cs_q, cs_d, sk_q, sk_d, done_q, done_d;
  logic                ld;
  logic [CW-1:0]       ld_val;
  logic                t_zero;

  mw_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(ld), .load_val_i(ld_val), .zero_o(t_zero)
  );

  always_comb begin
    state_d = state_q;
    tx_d    = tx_q;
    rx_d    = rx_q;
    bit_d   = bit_q;
    cs_d    = cs_q;
    sk_d    = sk_q;
    done_d  = 1'b0;
    ld      = 1'b0;
    ld_val  = '0;
    unique case (state_q)
      E_IDLE: if (go_i) begin
        state_d = E_CSS;
        cs_d    = 1'b1;
        tx_d    = READ_CMD_BASE | FRAME_W'(addr_i);
        bit_d   = '0;
        ld      = 1'b1;
        ld_val  = CW'(CSS_C - 1);
      end
      E_CSS: if (t_zero) begin
        state_d = E_LOW;
        ld      = 1'b1;
        ld_val  = CW'(LOW_C - 1);
      end
      E_LOW: if (t_zero) begin
        state_d = E_HIGH;
        sk_d    = 1'b1;
        ld      = 1'b1;
        ld_val  = CW'(HIGH_C - 1);
      end
      E_HIGH: if (t_zero) begin
        sk_d = 1'b0;
        tx_d = {tx_q[FRAME_W-2:0], 1'b0};
        if (bit_q >= FIRST_RX) rx_d = {rx_q[WORD_W-2:0], do_sync_i};
        ld = 1'b1;
        if (bit_q == LAST_BIT) begin
          state_d = E_TAIL;
          cs_d    = 1'b0;
          ld_val  = CW'(CSH_C - 1);
        end else begin
          state_d = E_LOW;
          bit_d   = bit_q + 1'b1;
          ld_val  = CW'(LOW_C - 1);
        end
      end
      E_TAIL: if (t_zero) begin
        state_d = E_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = E_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= E_IDLE;
      tx_q    <= '0;
      rx_q    <= '0;
      bit_q   <= '0;
      cs_q    <= 1'b0;
      sk_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      tx_q    <= tx_d;
      rx_q    <= rx_d;
      bit_q   <= bit_d;
      cs_q    <= cs_d;
      sk_q    <= sk_d;
      done_q  <= done_d;
    end
  end

  assign cs_o   = cs_q;
  assign sk_o   = sk_q;
  assign di_o   = tx_q[FRAME_W-1];
  assign word_o = rx_q;
  assign done_o = done_q;
endmodule

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader
  import mw_pkg::*;
#(
  parameter int CLK_KHZ     = 50_000,
  parameter int T_CSS_NS    = 1000,
  parameter int T_SETUP_NS  = 400,
  parameter int T_HIGH_NS   = 2000,
  parameter int T_LOW_NS    = 2000,
  parameter int T_CSH_NS    = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        addr_mode_i,
  input  logic [3:0]  word_addr_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] word_o,
  output logic [47:0] station_o,
  output logic        ee_cs_o,
  output logic        ee_sk_o,
  output logic        ee_di_o,
  input  logic        ee_do_i
);
  localparam int CSS_C  = imax(1, ns_to_cyc(T_CSS_NS, CLK_KHZ));
  localparam int LOW_C  = imax(1, imax(ns_to_cyc(T_LOW_NS, CLK_KHZ), ns_to_cyc(T_SETUP_NS, CLK_KHZ)));
  localparam int HIGH_C = imax(SYNC_STAGES + 1, ns_to_cyc(T_HIGH_NS, CLK_KHZ));
  localparam int CSH_C  = imax(1, ns_to_cyc(T_CSH_NS, CLK_KHZ));
  localparam logic [1:0] LAST_IDX = 2'(STATION_WORDS - 1);

  logic                 do_sync, eng_done;
  logic [WORD_W-1:0]    eng_word;
  logic                 busy_q, busy_d, mode_q, mode_d, go_q, go_d, done_q, done_d;
  logic [1:0]           idx_q, idx_d;
  logic [ADDR_W-1:0]    addr_q, addr_d;
  logic [WORD_W-1:0]    word_q, word_d;
  logic [STATION_W-1:0] stn_q, stn_d;

  mw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(ee_do_i), .q_o(do_sync)
  );

  mw_word_engine #(
    .CSS_C(CSS_C), .LOW_C(LOW_C), .HIGH_C(HIGH_C), .CSH_C(CSH_C)
  ) u_engine (
    .clk(clk), .rst_n(rst_n), .go_i(go_q), .addr_i(addr_q), .do_sync_i(do_sync),
    .cs_o(ee_cs_o), .sk_o(ee_sk_o), .di_o(ee_di_o), .word_o(eng_word), .done_o(eng_done)
  );

  always_comb begin
    busy_d = busy_q;
    mode_d = mode_q;
    idx_d  = idx_q;
    addr_d = addr_q;
    word_d = word_q;
    stn_d  = stn_q;
    go_d   = 1'b0;
    done_d = 1'b0;
    if (!busy_q) begin
      if (start_i) begin
        busy_d = 1'b1;
        mode_d = addr_mode_i;
        idx_d  = '0;
        addr_d = addr_mode_i ? '0 : word_addr_i;
        go_d   = 1'b1;
      end
    end else if (eng_done) begin
      word_d = eng_word;
      if (mode_q) stn_d[(STATION_WORDS - 1 - int'(idx_q)) * WORD_W +: WORD_W] = eng_word;
      if (mode_q && (idx_q != LAST_IDX)) begin
        idx_d  = idx_q + 1'b1;
        addr_d = ADDR_W'(idx_q + 1'b1);
        go_d   = 1'b1;
      end else begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      mode_q <= 1'b0;
      idx_q  <= '0;
      addr_q <= '0;
      word_q <= '0;
      stn_q  <= '0;
      go_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      mode_q <= mode_d;
      idx_q  <= idx_d;
      addr_q <= addr_d;
      word_q <= word_d;
      stn_q  <= stn_d;
      go_q   <= go_d;
      done_q <= done_d;
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign word_o    = word_q;
  assign station_o = stn_q;
endmodule

// File: rtl/mw_eeprom_reader_chk.sv
module mw_eeprom_reader_chk #(
  parameter int HIGH_C = 100,
  parameter int LOW_C  = 100,
  parameter int CSH_C  = 50
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ee_cs,
  input logic        ee_sk,
  input logic        ee_di,
  input logic        busy,
  input logic        done,
  input logic [47:0] station
);
  localparam int RW = 16;
  localparam logic [RW-1:0] SAT = '1;

  logic [RW-1:0] hi_run, lo_run, gap_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run  <= '0;
      lo_run  <= '0;
      gap_run <= RW'(CSH_C);
    end else begin
      hi_run  <= ee_sk ? ((hi_run == SAT) ? hi_run : hi_run + 1'b1) : '0;
      lo_run  <= (ee_cs && !ee_sk) ? ((lo_run == SAT) ? lo_run : lo_run + 1'b1) : '0;
      gap_run <= ee_cs ? '0 : ((gap_run == SAT) ? gap_run : gap_run + 1'b1);
    end
  end

  AST_DI_STABLE_SK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_di));  // R2
  AST_SK_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> ee_cs);  // R3
  AST_HIGH_PHASE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ee_sk) |-> (int'(hi_run) >= HIGH_C));  // R4
  AST_LOW_PHASE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_sk) |-> (int'(lo_run) >= LOW_C));  // R4
  AST_CS_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_cs) |-> (int'(gap_run) >= CSH_C));  // R7
  AST_IDLE_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ee_cs);  // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);  // R8
  AST_STATION_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(station));  // R10
endmodule

bind mw_eeprom_reader mw_eeprom_reader_chk #(
  .HIGH_C(HIGH_C), .LOW_C(LOW_C), .CSH_C(CSH_C)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ee_cs(ee_cs_o), .ee_sk(ee_sk_o), .ee_di(ee_di_o),
  .busy(busy_o), .done(done_o), .station(station_o)
);

// File: tb/mw_eeprom_reader_bench.sv
module mw_eeprom_reader_bench;
  localparam int EXP_CSS  = 50;
  localparam int EXP_LOW  = 100;
  localparam int EXP_HIGH = 100;
  localparam int EXP_CSH  = 50;
  localparam int WORD_LIMIT = 8000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, amode = 1'b0;
  logic [3:0] waddr = '0;
  logic busy, done, ee_cs, ee_sk, ee_di;
  logic ee_do = 1'b0;
  logic [15:0] word;
  logic [47:0] station;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  mw_eeprom_reader u_mw_eeprom_reader (
    .clk(clk), .rst_n(rst_n), .start_i(start), .addr_mode_i(amode), .word_addr_i(waddr),
    .busy_o(busy), .done_o(done), .word_o(word), .station_o(station),
    .ee_cs_o(ee_cs), .ee_sk_o(ee_sk), .ee_di_o(ee_di), .ee_do_i(ee_do)
  );

  function automatic logic [15:0] mem_word(input logic [3:0] a);
    return (16'h1357 * (16'(a) + 16'd3)) ^ 16'hA55A;
  endfunction

  // EEPROM model and frame log
  logic [9:0] frame_log [32];
  int         clk_log   [32];
  bit         dibad_log [32];
  int         frame_n = 0;
  logic [9:0] cmd_sh;
  int         bitn;
  bit         di_bad;
  logic       cs_prev = 1'b0, sk_prev = 1'b0;

  always @(ee_cs, ee_sk) begin
    if (ee_cs === 1'b1 && cs_prev !== 1'b1) begin
      cmd_sh = '0; bitn = 0; di_bad = 1'b0;
    end else if (ee_cs !== 1'b1 && cs_prev === 1'b1) begin
      frame_log[frame_n % 32] = cmd_sh;
      clk_log[frame_n % 32]   = bitn;
      dibad_log[frame_n % 32] = di_bad;
      frame_n++;
    end
    if (ee_sk === 1'b1 && sk_prev !== 1'b1 && ee_cs === 1'b1) begin
      if (bitn < 10) cmd_sh = {cmd_sh[8:0], ee_di};
      else if (ee_di !== 1'b0) di_bad = 1'b1;
      if (bitn >= 10 && bitn < 26) begin
        logic [15:0] w;
        w = mem_word(cmd_sh[3:0]);
        ee_do = w[25 - bitn];
      end
      bitn++;
    end
    cs_prev = ee_cs;
    sk_prev = ee_sk;
  end

  // Timing monitor
  int hi_run = 0, lo_run = 0, css_run = 0, gap_run = 0, accesses = 0;
  int min_hi = 1 << 30, min_lo = 1 << 30, min_css = 1 << 30, min_gap = 1 << 30;
  bit first_pending = 0;
  logic mcs_p = 1'b0, msk_p = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ee_cs && !mcs_p) begin
        if (accesses > 0 && gap_run < min_gap) min_gap = gap_run;
        accesses++; first_pending = 1; css_run = 0; lo_run = 0;
      end
      if (ee_sk && !msk_p) begin
        if (first_pending) begin
          if (css_run < min_css) min_css = css_run;
          first_pending = 0;
        end else if (lo_run < min_lo) min_lo = lo_run;
        lo_run = 0;
      end
      if (!ee_sk && msk_p) begin
        if (hi_run < min_hi) min_hi = hi_run;
        hi_run = 0;
      end
      if (ee_sk) hi_run++;
      if (ee_cs && !ee_sk) lo_run++;
      if (ee_cs && first_pending) css_run++;
      if (ee_cs) gap_run = 0; else gap_run++;
      mcs_p = ee_cs; msk_p = ee_sk;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start(input bit m, input logic [3:0] a);
    @(negedge clk); start = 1'b1; amode = m; waddr = a;
    @(negedge clk); start = 1'b0; amode = 1'b0; waddr = '0;
  endtask

  task automatic wait_done(input int limit, output bit ok);
    ok = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
    check(ok, "R8 done seen (watchdog)", 64'(ok), 64'd1);
  endtask

  task automatic check_done_pulse(input string tag);
    logic [15:0] w0; logic [47:0] s0;
    check(busy == 1'b0, {tag, " R8 busy low at done"}, 64'(busy), 64'd0);
    w0 = word; s0 = station;
    @(negedge clk);
    check(done == 1'b0, {tag, " R8 done one cycle"}, 64'(done), 64'd0);
    repeat (20) @(negedge clk);
    check(word == w0 && station == s0, {tag, " R8 outputs held"}, {word, s0}, {w0, s0});
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check({ee_cs, ee_sk, ee_di, busy, done} == 5'b0, "R1 controls in reset",
          64'({ee_cs, ee_sk, ee_di, busy, done}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(word == '0 && station == '0 && !ee_cs, "R1 outputs after reset",
          {word, station}, 64'd0);
  endtask

  task automatic t_single(input logic [3:0] a);
    int f0; bit ok; logic [47:0] s0;
    f0 = frame_n; s0 = station;
    pulse_start(1'b0, a);
    check(busy == 1'b1, "R8 busy during read", 64'(busy), 64'd1);
    wait_done(WORD_LIMIT, ok);
    check(frame_n - f0 == 1, "R6 one access per read", 64'(frame_n - f0), 64'd1);
    check(frame_log[f0 % 32] == (10'h180 | 10'(a)), "R2 command frame",
          64'(frame_log[f0 % 32]), 64'(10'h180 | 10'(a)));
    check(clk_log[f0 % 32] == 26, "R6 clock edges", 64'(clk_log[f0 % 32]), 64'd26);
    check(!dibad_log[f0 % 32], "R5 data-in low in data phase", 64'(dibad_log[f0 % 32]), 64'd0);
    check(word == mem_word(a), "R5 word value", 64'(word), 64'(mem_word(a)));
    check(station == s0, "R10 station untouched by single read", station, s0);
    check_done_pulse("single");
  endtask

  task automatic t_busy_ignore();
    int f0; bit ok; logic [47:0] s0;
    f0 = frame_n; s0 = station;
    pulse_start(1'b0, 4'd3);
    repeat (300) @(negedge clk);
    pulse_start(1'b1, 4'd9);
    wait_done(WORD_LIMIT, ok);
    check(word == mem_word(4'd3), "R9 word of first request", 64'(word), 64'(mem_word(4'd3)));
    check(frame_log[f0 % 32] == 10'h183, "R9 frame of first request",
          64'(frame_log[f0 % 32]), 64'h183);
    repeat (400) @(negedge clk);
    check(frame_n - f0 == 1 && !busy, "R9 no extra access", 64'(frame_n - f0), 64'd1);
    check(station == s0, "R9 station unchanged", station, s0);
  endtask

  task automatic t_station();
    int f0; bit ok; logic [47:0] exp;
    f0 = frame_n;
    exp = {mem_word(4'd0), mem_word(4'd1), mem_word(4'd2)};
    pulse_start(1'b1, 4'd12);
    wait_done(3 * WORD_LIMIT, ok);
    check(frame_n - f0 == 3, "R10 three accesses", 64'(frame_n - f0), 64'd3);
    for (int k = 0; k < 3; k++)
      check(frame_log[(f0 + k) % 32] == (10'h180 | 10'(k)), "R10 word order",
            64'(frame_log[(f0 + k) % 32]), 64'(10'h180 | 10'(k)));
    check(station == exp, "R10 station value", station, exp);
    check(station[47:40] == mem_word(4'd0)[15:8], "R10 upper byte first",
          64'(station[47:40]), 64'(mem_word(4'd0)[15:8]));
    check(word == mem_word(4'd2), "R10 last word on word_o", 64'(word), 64'(mem_word(4'd2)));
    check_done_pulse("station");
  endtask

  task automatic t_timing();
    check(min_css >= EXP_CSS, "R3 select setup", 64'(min_css), 64'(EXP_CSS));
    check(min_hi >= EXP_HIGH, "R4 high phase", 64'(min_hi), 64'(EXP_HIGH));
    check(min_lo >= EXP_LOW, "R4 low phase", 64'(min_lo), 64'(EXP_LOW));
    check(min_gap >= EXP_CSH, "R7 select idle gap", 64'(min_gap), 64'(EXP_CSH));
    check(!ee_cs && !busy, "R7 select low when idle", 64'(ee_cs), 64'd0);
  endtask

  initial begin
    t_reset();
    t_single(4'd0);
    t_single(4'd15);
    t_station();
    t_single(4'd5);
    t_busy_ignore();
    t_single(4'd10);
    t_timing();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule